// File: doc/BRIEF.md
# Transmit Gearbox with Bit Reversal and Lane Slip

This block adapts wide parallel words from the fabric to a 40-bit bus that feeds a serializer, all on one clock. Input words are 66 bits wide in the narrow mode and 67 bits wide in the wide mode. The bits are packed into a bit-accurate accumulation buffer. The oldest buffered bits always leave first, at the lowest positions of the output bus. Because the output consumes fewer bits per cycle than one input word carries, the block raises a ready signal only on the cycles when it can take a whole word. The fabric qualifies each word with a valid signal.

Two controls shape the serial order. A static reversal option mirrors each word before packing, so the top bit of the word goes out first. A slip request from the fabric delays the stream by up to 39 bit positions, which compensates for skew between lanes. The block applies a change in the slip value at the next accepted word. An increase inserts zero bits once. A decrease removes bits from the front of that word once.

A two-state machine governs the output. ST_PRIME is entered on reset and drives zeros while fewer than 40 bits are held. ST_PRIME goes to ST_RUN once the updated bit count reaches 40. ST_RUN emits the 40 oldest bits every cycle. ST_RUN falls back to ST_PRIME when the updated count drops below 40, which happens when words are withheld or a large slip decrease removes bits.

Top module: `tx_gearbox`

## Requirements
- R1: On the first cycle after synchronous reset is released, dout is all zeros and din_ready is 1. The buffer is empty and the applied slip is 0.
- R2: With wide_mode=0 a word is din[65:0] and din[66] has no effect on dout. With wide_mode=1 a word is din[66:0].
- R3: dout[0] is the first bit serialized and dout[39] the last. Without reversal, din[0] of each word is the first bit of that word in the stream. Consecutive words are packed back to back with no gap.
- R4: With rev_en=1, each word is mirrored before packing, so din[W-1] goes out first, where W is 66 or 67.
- R5: Let F be the number of bits held after this cycle's output. din_ready is 1 exactly when F is less than 40 plus any pending slip decrease. A word is accepted when din_ready and din_valid are both 1. With din_valid held high this gives exactly 400 words every 660 cycles in the narrow mode and every 670 cycles in the wide mode. The buffer never holds more than 145 bits.
- R6: With din_valid held high, every cycle after the first accepted word carries 40 stream bits. No zero-filled gap appears.
- R7: If the clamped slip request exceeds the applied slip when a word is accepted, the difference in zero bits is placed in the stream just before that word. The request then becomes the applied slip.
- R8: If the clamped slip request is below the applied slip when a word is accepted, the difference in leading serial bits of that word is dropped. The request then becomes the applied slip.
- R9: A slip request above 39 acts exactly as 39.
- R10: When fewer than 40 bits are held at the start of a cycle, that cycle's dout is all zeros and no bits are consumed. Otherwise the 40 oldest bits are emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all logic |
| rst | input | 1 | Synchronous reset, active high |
| wide_mode | input | 1 | 0: 66-bit words, 1: 67-bit words (static) |
| rev_en | input | 1 | 1: mirror each word before packing (static) |
| slip_req | input | 6 | Requested stream delay in bits, clamped to 39 |
| din | input | 67 | Input word, LSB at bit 0 |
| din_valid | input | 1 | Fabric presents a word this cycle |
| din_ready | output | 1 | Block can take a whole word this cycle |
| dout | output | 40 | Output bus, bit 0 serialized first |

## Verification
Random words are pushed with valid held high in both widths and both reversal settings. This separates an LSB-first order from a mirrored one. Garbage on the unused top bit in narrow mode exposes a wrong width mask. The exact word counts over long windows pin down the ready pattern. Slip is then stepped up, stepped down, and requested beyond 39. A stepped request tells an insertion from a drop, and the large request separates clamping from raw use. A run with valid withheld at irregular times drains the buffer into the zero-output state and shows that the block recovers from it.

// File: rtl/txgb_pkg.sv
`timescale 1ns/1ps
package txgb_pkg;
    localparam int OUT_W    = 40;
    localparam int IN_MAX   = 67;
    localparam int IN_MIN   = 66;
    localparam int SLIP_MAX = OUT_W - 1;
    localparam int BUF_W    = OUT_W + IN_MAX + SLIP_MAX;
    localparam int SLIP_W   = $clog2(SLIP_MAX + 1);
    localparam int FILL_W   = $clog2(BUF_W + 1);
    localparam int LEN_W    = $clog2(IN_MAX + 1);

    typedef enum logic {
        ST_PRIME = 1'b0,
        ST_RUN   = 1'b1
    } gb_state_e;
endpackage

// File: rtl/txgb_word_prep.sv
`timescale 1ns/1ps
module txgb_word_prep #(
    parameter int IN_MAX = txgb_pkg::IN_MAX,
    parameter int IN_MIN = txgb_pkg::IN_MIN,
    parameter int SLIP_W = txgb_pkg::SLIP_W,
    parameter int LEN_W  = txgb_pkg::LEN_W
) (
    input  logic [IN_MAX-1:0] din,
    input  logic              wide_mode,
    input  logic              rev_en,
    input  logic [SLIP_W-1:0] drop_n,
    output logic [IN_MAX-1:0] word,
    output logic [LEN_W-1:0]  len
);
    localparam logic [IN_MAX-1:0] NARROW_MASK = {IN_MAX{1'b1}} >> (IN_MAX - IN_MIN);

    logic [IN_MAX-1:0] mir_wide;
    logic [IN_MAX-1:0] mir_narrow;
    logic [IN_MAX-1:0] ordered;

    for (genvar i = 0; i < IN_MAX; i++) begin : g_mir
        assign mir_wide[i] = din[IN_MAX-1-i];
        if (i < IN_MIN) begin : g_n
            assign mir_narrow[i] = din[IN_MIN-1-i];
        end else begin : g_z
            assign mir_narrow[i] = 1'b0;
        end
    end

    always_comb begin
        if (rev_en) begin
            ordered = wide_mode ? mir_wide : mir_narrow;
        end else begin
            ordered = wide_mode ? din : (din & NARROW_MASK);
        end
        word = ordered >> drop_n;
        len  = (wide_mode ? LEN_W'(IN_MAX) : LEN_W'(IN_MIN)) - LEN_W'(drop_n);
    end
endmodule

// File: rtl/txgb_slip_ctl.sv
`timescale 1ns/1ps
module txgb_slip_ctl #(
    parameter int SLIP_W   = txgb_pkg::SLIP_W,
    parameter int SLIP_MAX = txgb_pkg::SLIP_MAX
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SLIP_W-1:0] slip_req,
    input  logic              accept,
    output logic [SLIP_W-1:0] ins_n,
    output logic [SLIP_W-1:0] drop_n,
    output logic [SLIP_W-1:0] slip_cur
);
    logic [SLIP_W-1:0] target;

    always_comb begin
        target = (slip_req > SLIP_W'(SLIP_MAX)) ? SLIP_W'(SLIP_MAX) : slip_req;
        ins_n  = (target > slip_cur) ? (target - slip_cur) : '0;
        drop_n = (slip_cur > target) ? (slip_cur - target) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slip_cur <= '0;
        end else if (accept) begin
            slip_cur <= target;
        end
    end
endmodule

// File: rtl/txgb_accum.sv
`timescale 1ns/1ps
module txgb_accum
    import txgb_pkg::*;
#(
    parameter int OUT_W  = txgb_pkg::OUT_W,
    parameter int IN_MAX = txgb_pkg::IN_MAX,
    parameter int BUF_W  = txgb_pkg::BUF_W,
    parameter int FILL_W = txgb_pkg::FILL_W,
    parameter int LEN_W  = txgb_pkg::LEN_W,
    parameter int SLIP_W = txgb_pkg::SLIP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IN_MAX-1:0] word,
    input  logic [LEN_W-1:0]  len,
    input  logic [SLIP_W-1:0] ins_n,
    input  logic [SLIP_W-1:0] drop_n,
    input  logic              din_valid,
    output logic              din_ready,
    output logic              accept,
    output logic [OUT_W-1:0]  dout,
    output logic [FILL_W-1:0] fill_o,
    output logic              run_o
);
    gb_state_e         state_q, state_d;
    logic [FILL_W-1:0] fill_q, fill_d, f1, shamt;
    logic [BUF_W-1:0]  buf_q, buf_d, buf_base, word_ext;
    logic              emit;

    always_comb begin
        emit      = (state_q == ST_RUN);
        f1        = emit ? (fill_q - FILL_W'(OUT_W)) : fill_q;
        din_ready = (f1 < (FILL_W'(OUT_W) + FILL_W'(drop_n)));
        accept    = din_ready & din_valid;
        shamt     = f1 + FILL_W'(ins_n);
        word_ext  = BUF_W'(word) << shamt;
        buf_base  = emit ? (buf_q >> OUT_W) : buf_q;
        buf_d     = accept ? (buf_base | word_ext) : buf_base;
        fill_d    = f1 + (accept ? (FILL_W'(len) + FILL_W'(ins_n)) : '0);
        unique case (state_q)
            ST_PRIME: state_d = (fill_d >= FILL_W'(OUT_W)) ? ST_RUN : ST_PRIME;
            ST_RUN:   state_d = (fill_d <  FILL_W'(OUT_W)) ? ST_PRIME : ST_RUN;
            default:  state_d = ST_PRIME;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_PRIME;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q <= '0;
            buf_q  <= '0;
        end else begin
            fill_q <= fill_d;
            buf_q  <= buf_d;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else begin
            unique case (state_q)
                ST_RUN:   dout <= buf_q[OUT_W-1:0];
                ST_PRIME: dout <= '0;
                default:  dout <= '0;
            endcase
        end
    end

    assign fill_o = fill_q;
    assign run_o  = emit;
endmodule

// File: rtl/tx_gearbox.sv
`timescale 1ns/1ps
module tx_gearbox #(
    parameter int OUT_W    = txgb_pkg::OUT_W,
    parameter int IN_MAX   = txgb_pkg::IN_MAX,
    parameter int IN_MIN   = txgb_pkg::IN_MIN,
    parameter int SLIP_MAX = OUT_W - 1,
    parameter int BUF_W    = OUT_W + IN_MAX + SLIP_MAX,
    parameter int SLIP_W   = $clog2(SLIP_MAX + 1),
    parameter int FILL_W   = $clog2(BUF_W + 1),
    parameter int LEN_W    = $clog2(IN_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wide_mode,
    input  logic              rev_en,
    input  logic [SLIP_W-1:0] slip_req,
    input  logic [IN_MAX-1:0] din,
    input  logic              din_valid,
    output logic              din_ready,
    output logic [OUT_W-1:0]  dout
);
    logic [IN_MAX-1:0] word;
    logic [LEN_W-1:0]  len;
    logic [SLIP_W-1:0] ins_n, drop_n, slip_cur;
    logic              accept;
    logic [FILL_W-1:0] fill_mon;
    logic              run_mon;

    txgb_word_prep #(
        .IN_MAX(IN_MAX), .IN_MIN(IN_MIN), .SLIP_W(SLIP_W), .LEN_W(LEN_W)
    ) u_prep (
        .din(din), .wide_mode(wide_mode), .rev_en(rev_en),
        .drop_n(drop_n), .word(word), .len(len)
    );

    txgb_slip_ctl #(
        .SLIP_W(SLIP_W), .SLIP_MAX(SLIP_MAX)
    ) u_slip (
        .clk(clk), .rst(rst), .slip_req(slip_req), .accept(accept),
        .ins_n(ins_n), .drop_n(drop_n), .slip_cur(slip_cur)
    );

    txgb_accum #(
        .OUT_W(OUT_W), .IN_MAX(IN_MAX), .BUF_W(BUF_W),
        .FILL_W(FILL_W), .LEN_W(LEN_W), .SLIP_W(SLIP_W)
    ) u_acc (
        .clk(clk), .rst(rst), .word(word), .len(len),
        .ins_n(ins_n), .drop_n(drop_n), .din_valid(din_valid),
        .din_ready(din_ready), .accept(accept), .dout(dout),
        .fill_o(fill_mon), .run_o(run_mon)
    );
endmodule

// File: rtl/txgb_checker.sv
`timescale 1ns/1ps
module txgb_checker #(
    parameter int OUT_W    = txgb_pkg::OUT_W,
    parameter int BUF_W    = txgb_pkg::BUF_W,
    parameter int SLIP_MAX = txgb_pkg::SLIP_MAX,
    parameter int SLIP_W   = txgb_pkg::SLIP_W,
    parameter int FILL_W   = txgb_pkg::FILL_W
) (
    input logic              clk,
    input logic              rst,
    input logic              din_ready,
    input logic              accept,
    input logic [OUT_W-1:0]  dout,
    input logic [FILL_W-1:0] fill,
    input logic              run,
    input logic [SLIP_W-1:0] drop_n,
    input logic [SLIP_W-1:0] slip_cur
);
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dout == '0 && din_ready));

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        fill <= FILL_W'(BUF_W - 1));

    p_prime_ready_r5: assert property (@(posedge clk) disable iff (rst)
        (!run && drop_n == '0) |-> din_ready);

    p_accept_runs_r6: assert property (@(posedge clk) disable iff (rst)
        (accept && drop_n == '0) |=> run);

    p_slip_clamp_r9: assert property (@(posedge clk) disable iff (rst)
        slip_cur <= SLIP_W'(SLIP_MAX));

    p_prime_zero_r10: assert property (@(posedge clk) disable iff (rst)
        !run |=> (dout == '0));
endmodule

bind tx_gearbox txgb_checker #(
    .OUT_W(OUT_W), .BUF_W(BUF_W), .SLIP_MAX(SLIP_MAX),
    .SLIP_W(SLIP_W), .FILL_W(FILL_W)
) u_chk (
    .clk(clk), .rst(rst), .din_ready(din_ready), .accept(accept),
    .dout(dout), .fill(fill_mon), .run(run_mon),
    .drop_n(drop_n), .slip_cur(slip_cur)
);

// File: tb/tx_gearbox_tb_top.sv
`timescale 1ns/1ps
module tx_gearbox_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wide_mode = 1'b0;
    logic        rev_en = 1'b0;
    logic [5:0]  slip_req = '0;
    logic [66:0] din = '0;
    logic        din_valid = 1'b0;
    logic        din_ready;
    logic [39:0] dout;

    bit    q[$];
    int    slip_m;
    int    n_cmp = 0;
    int    n_bad = 0;
    int    n_acc = 0;
    int    n_zero = 0;
    string tag = "R3";

    always #5 clk = ~clk;

    tx_gearbox dut_i (
        .clk(clk), .rst(rst), .wide_mode(wide_mode), .rev_en(rev_en),
        .slip_req(slip_req), .din(din), .din_valid(din_valid),
        .din_ready(din_ready), .dout(dout)
    );

    task automatic chk(input string t, input logic [39:0] act, input logic [39:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", t, act, exp);
        end
    endtask

    function automatic logic [66:0] rnd67();
        return {$urandom(), $urandom(), $urandom()};
    endfunction

    task automatic do_reset(input logic wide, input logic rev);
        @(negedge clk);
        rst = 1'b1; din_valid = 1'b0; wide_mode = wide; rev_en = rev; slip_req = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        q.delete();
        slip_m = 0;
        #1;
        chk("R1 ready", {39'b0, din_ready}, 40'd1);
        chk("R1 dout", dout, 40'd0);
    endtask

    // one clock: drive, check ready, update model, check registered output
    task automatic step(input logic v, input logic [66:0] w, input int s);
        logic [39:0] exp_out;
        bit          emit;
        int          f1, eff, d, ins, width;
        logic        exp_rdy;
        @(negedge clk);
        din_valid = v; din = w; slip_req = s[5:0];
        #1;
        exp_out = '0;
        emit = (q.size() >= 40);
        if (emit) begin
            for (int j = 0; j < 40; j++) exp_out[j] = q.pop_front();
        end
        f1  = q.size();
        eff = (s > 39) ? 39 : s;
        d   = (slip_m > eff) ? slip_m - eff : 0;
        ins = (eff > slip_m) ? eff - slip_m : 0;
        exp_rdy = (f1 < 40 + d);
        chk({tag, " ready"}, {39'b0, din_ready}, {39'b0, exp_rdy});
        if (exp_rdy && v) begin
            width = wide_mode ? 67 : 66;
            for (int k = 0; k < ins; k++) q.push_back(1'b0);
            for (int k = d; k < width; k++)
                q.push_back(rev_en ? w[width-1-k] : w[k]);
            slip_m = eff;
            n_acc++;
        end
        @(posedge clk);
        #1;
        chk({tag, " dout"}, dout, exp_out);
        if (dout == '0) n_zero++;
    endtask

    task automatic run(input int n, input int s);
        for (int i = 0; i < n; i++) step(1'b1, rnd67(), s);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R6 watchdog act=timeout exp=done");
        summary();
        $finish;
    end

    initial begin
        // R3: narrow words, LSB first; R6 no gaps; R5 rate 400 per 660
        tag = "R3";
        do_reset(1'b0, 1'b0);
        run(2, 0);
        n_zero = 0;
        run(58, 0);
        chk("R6 gaps", 40'(n_zero), 40'd0);
        n_acc = 0;
        run(660, 0);
        chk("R5 narrow rate", 40'(n_acc), 40'd400);

        // R4: narrow mirrored
        tag = "R4";
        do_reset(1'b0, 1'b1);
        run(300, 0);

        // R2: wide words, R5 rate 400 per 670
        tag = "R2";
        do_reset(1'b1, 1'b0);
        run(60, 0);
        n_acc = 0;
        run(670, 0);
        chk("R5 wide rate", 40'(n_acc), 40'd400);

        // R4: wide mirrored
        tag = "R4";
        do_reset(1'b1, 1'b1);
        run(300, 0);

        // R7: slip increases
        tag = "R7";
        do_reset(1'b0, 1'b0);
        run(80, 0);
        run(80, 5);
        run(80, 17);
        run(80, 39);

        // R8: slip decreases
        tag = "R8";
        run(80, 30);
        run(80, 3);
        run(80, 0);

        // R9: requests above 39
        tag = "R9";
        do_reset(1'b1, 1'b1);
        run(80, 50);
        run(80, 63);
        run(80, 10);
        run(80, 45);

        // R10: withheld words drain the buffer
        tag = "R10";
        do_reset(1'b1, 1'b0);
        for (int i = 0; i < 600; i++)
            step(($urandom() % 5) != 0 && (i % 97) > 6, rnd67(), (i / 150) * 9);

        summary();
        $finish;
    end
endmodule